// File: doc/BRIEF.md
# SDRAM Read-Burst Precharge Scheduler

This block drives the command and address pins for one bank of an SDR SDRAM during a read. It takes one request, which holds a bank, a column, a follow-on row, a burst mode and a count of wanted data words. It then issues READ, a string of NOPs, a PRECHARGE and finally an ACTIVE that reopens the bank on the given row.

The row is closed as early as the wanted data allows. A PRECHARGE issued CAS-latency-minus-one cycles ahead of the last wanted word still lets that word out of the device. The same rule means the command lands exactly `wanted` cycles after READ, for either latency. This cuts fixed bursts short, always ends full-page bursts, and hides part of the row-precharge time behind the final data.

Reads that ask for auto precharge are never cut short by an explicit command. The bank reopens only after the programmed precharge period. Read data is represented by a valid strobe.

Top module: `sdram_rd_pre_sched`

## Requirements
- R1: While and after a synchronous reset the command bus carries NOP (ras_n,cas_n,we_n = 111), address and bank are 0, and rd_valid, done and busy are low.
- R2: A request is taken only at a clock edge where req_valid is high and busy is low. READ (101) appears on the next cycle, with the column in the low address bits, address bit 10 equal to the effective auto-precharge flag, and the request's bank.
- R3: For a full-page burst, or a fixed burst without auto precharge whose wanted count is below its length, PRECHARGE (010) is issued `wanted` cycles after READ. That is CAS latency minus one cycles before the last wanted word is valid.
- R4: A fixed burst with a wanted count at or above its length (1, 2, 4 or 8 for length selector 0..3) gets its PRECHARGE exactly burst-length cycles after READ.
- R5: A wanted count of 0 is treated as 1, so PRECHARGE follows READ on the very next cycle.
- R6: A fixed burst with auto precharge issues no PRECHARGE. Its hidden precharge period starts burst-length cycles after READ.
- R7: For full-page bursts the auto-precharge request is ignored: READ carries address bit 10 low and an explicit PRECHARGE ends the burst.
- R8: PRECHARGE carries address bit 10 equal to req_pre_all (1 means all banks) and the request's bank. All other address bits are 0.
- R9: ACTIVE (011), with the row on the address bits, is issued tRP cycles after the precharge start, where tRP comes from trp_cfg captured with the request and a value of 0 counts as 1.
- R10: Every other command cycle from READ through ACTIVE, and every idle cycle, is NOP with address and bank 0.
- R11: rd_valid is high from READ plus the CAS latency (2 when cl3_sel is 0, 3 when it is 1, captured with the request) for as many cycles as words are wanted, capped at the burst length for fixed bursts.
- R12: done pulses for one cycle with ACTIVE. busy is high from the READ cycle through the ACTIVE cycle.
- R13: dqm stays low at all times.
- R14: A request presented while busy is high is ignored and does not change the command sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cl3_sel | input | 1 | CAS latency select: 0 = 2, 1 = 3 |
| trp_cfg | input | TRP_W | Row-precharge period in cycles |
| req_valid | input | 1 | Request strobe |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Row opened by the closing ACTIVE |
| req_col | input | COL_W | Start column |
| req_full_page | input | 1 | Full-page burst |
| req_bl_sel | input | 2 | Fixed burst length selector (length = 2^sel) |
| req_want | input | WANT_W | Wanted data words |
| req_auto_pre | input | 1 | Read with auto precharge |
| req_pre_all | input | 1 | PRECHARGE targets all banks |
| cmd_rcw | output | 3 | {ras_n, cas_n, we_n} |
| cmd_addr | output | ADDR_W | Command address bus |
| cmd_ba | output | BANK_W | Command bank address |
| dqm | output | 1 | Data mask, held low |
| rd_valid | output | 1 | Read data valid strobe |
| done | output | 1 | Sequence complete pulse |
| busy | output | 1 | Sequence in progress |

## Verification
READ is due on the cycle after the accepting edge. PRECHARGE is due P cycles later, where P is the wanted, capped or burst length. ACTIVE follows P plus tRP cycles after READ. rd_valid starts at READ plus the CAS latency. For each request the bench computes this whole trace, cycle by cycle and indexed from READ, and queues it at the accepting edge. A monitor pops one entry at every falling edge and compares every output field, so each result is checked in exactly the cycle it is due. The stimulus includes a junk request issued mid-sequence, which must leave the trace unchanged.

// File: rtl/sdram_rd_pre_pkg.sv
package sdram_rd_pre_pkg;

   // {ras_n, cas_n, we_n}
   typedef enum logic [2:0] {
      CMD_ACT = 3'b011,
      CMD_RD  = 3'b101,
      CMD_PRE = 3'b010,
      CMD_NOP = 3'b111
   } cmd_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_READ,
      ST_TRP,
      ST_OPEN
   } seq_st_e;

   localparam int unsigned MIN_CL = 2;
   localparam int unsigned MAX_CL = 3;

endpackage

// File: rtl/sdram_rd_pre_plan.sv
module sdram_rd_pre_plan #(
   parameter int unsigned WANT_W   = 11,
   parameter int unsigned BL_SEL_W = 2
) (
   input  logic [WANT_W-1:0]   want,
   input  logic [BL_SEL_W-1:0] bl_sel,
   input  logic                full_page,
   input  logic                auto_req,
   output logic [WANT_W-1:0]   pre_off,
   output logic [WANT_W-1:0]   dv_len,
   output logic                explicit_pre,
   output logic                auto_eff
);

   localparam int unsigned MAX_BL_LOG = (1 << BL_SEL_W) - 1;

   if (WANT_W <= MAX_BL_LOG) begin : g_bad_want_w
      $error("WANT_W too small for the longest fixed burst");
   end

   logic [WANT_W-1:0] burst_len;
   logic [WANT_W-1:0] want_eff;
   logic [WANT_W-1:0] capped;

   always_comb begin
      burst_len = {{(WANT_W-1){1'b0}}, 1'b1} << bl_sel;
      want_eff  = (want == '0) ? {{(WANT_W-1){1'b0}}, 1'b1} : want;
      capped    = (want_eff < burst_len) ? want_eff : burst_len;
      if (full_page) begin
         pre_off      = want_eff;
         dv_len       = want_eff;
         explicit_pre = 1'b1;
         auto_eff     = 1'b0;
      end else if (auto_req) begin
         pre_off      = burst_len;
         dv_len       = capped;
         explicit_pre = 1'b0;
         auto_eff     = 1'b1;
      end else begin
         pre_off      = capped;
         dv_len       = capped;
         explicit_pre = 1'b1;
         auto_eff     = 1'b0;
      end
   end

endmodule

// File: rtl/sdram_rd_pre_seq.sv
module sdram_rd_pre_seq
   import sdram_rd_pre_pkg::*;
#(
   parameter int unsigned BANK_W = 2,
   parameter int unsigned ROW_W  = 13,
   parameter int unsigned COL_W  = 10,
   parameter int unsigned ADDR_W = 13,
   parameter int unsigned AP_BIT = 10,
   parameter int unsigned WANT_W = 11,
   parameter int unsigned TRP_W  = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic [BANK_W-1:0] bank,
   input  logic [ROW_W-1:0]  row,
   input  logic [COL_W-1:0]  col,
   input  logic              pre_all,
   input  logic [TRP_W-1:0]  trp,
   input  logic [WANT_W-1:0] pre_off,
   input  logic [WANT_W-1:0] dv_len,
   input  logic              explicit_pre,
   input  logic              auto_eff,
   output logic [2:0]        cmd,
   output logic [ADDR_W-1:0] addr,
   output logic [BANK_W-1:0] ba,
   output logic              done,
   output logic              busy,
   output logic              accept,
   output logic              src_valid
);

   if (COL_W > AP_BIT) begin : g_bad_col
      $error("column must sit below the auto-precharge bit");
   end
   if (ROW_W > ADDR_W || AP_BIT >= ADDR_W) begin : g_bad_addr
      $error("address bus too narrow");
   end

   seq_st_e           st;
   logic [WANT_W-1:0] cnt;
   logic [WANT_W-1:0] pre_off_q;
   logic [WANT_W-1:0] dv_left;
   logic [TRP_W-1:0]  tcnt;
   logic [TRP_W-1:0]  trp_q;
   logic              explicit_q;
   logic              pre_all_q;
   logic [BANK_W-1:0] bank_q;
   logic [ROW_W-1:0]  row_q;
   logic [ADDR_W-1:0] rd_addr;
   logic [ADDR_W-1:0] pre_addr;
   logic [ADDR_W-1:0] act_addr;

   assign accept    = req_valid && (st == ST_IDLE);
   assign busy      = (st != ST_IDLE);
   assign src_valid = (dv_left != '0);

   always_comb begin
      rd_addr              = '0;
      rd_addr[COL_W-1:0]   = col;
      rd_addr[AP_BIT]      = auto_eff;
      pre_addr             = '0;
      pre_addr[AP_BIT]     = pre_all_q;
      act_addr             = '0;
      act_addr[ROW_W-1:0]  = row_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st         <= ST_IDLE;
         cmd        <= CMD_NOP;
         addr       <= '0;
         ba         <= '0;
         done       <= 1'b0;
         cnt        <= '0;
         tcnt       <= '0;
         trp_q      <= '0;
         pre_off_q  <= '0;
         dv_left    <= '0;
         explicit_q <= 1'b0;
         pre_all_q  <= 1'b0;
         bank_q     <= '0;
         row_q      <= '0;
      end else begin
         cmd  <= CMD_NOP;
         addr <= '0;
         ba   <= '0;
         done <= 1'b0;
         if (dv_left != '0) dv_left <= dv_left - 1'b1;
         unique case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  st         <= ST_READ;
                  cmd        <= CMD_RD;
                  addr       <= rd_addr;
                  ba         <= bank;
                  cnt        <= {{(WANT_W-1){1'b0}}, 1'b1};
                  pre_off_q  <= pre_off;
                  dv_left    <= dv_len;
                  explicit_q <= explicit_pre;
                  pre_all_q  <= pre_all;
                  bank_q     <= bank;
                  row_q      <= row;
                  trp_q      <= (trp == '0) ? {{(TRP_W-1){1'b0}}, 1'b1} : trp;
               end
            end
            ST_READ: begin
               if (cnt == pre_off_q) begin
                  st   <= ST_TRP;
                  tcnt <= {{(TRP_W-1){1'b0}}, 1'b1};
                  if (explicit_q) begin
                     cmd  <= CMD_PRE;
                     addr <= pre_addr;
                     ba   <= bank_q;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_TRP: begin
               if (tcnt >= trp_q) begin
                  st   <= ST_OPEN;
                  cmd  <= CMD_ACT;
                  addr <= act_addr;
                  ba   <= bank_q;
                  done <= 1'b1;
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            ST_OPEN: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   // checker counter: cycles since the last explicit PRECHARGE, saturating
   logic [TRP_W:0] since_pre;
   always_ff @(posedge clk) begin
      if (rst) since_pre <= '0;
      else if (cmd == CMD_PRE) since_pre <= {{TRP_W{1'b0}}, 1'b1};
      else if (since_pre != '0 && since_pre != '1) since_pre <= since_pre + 1'b1;
   end

   // R2
   accept_rd_chk: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !busy) |=> (cmd == CMD_RD));
   // R6
   no_pre_auto_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd == CMD_PRE) |-> explicit_q);
   // R9
   trp_gap_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd == CMD_ACT && explicit_q) |-> (since_pre == {1'b0, trp_q}));
   // R10
   rd_then_nop_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd == CMD_RD) |=> (cmd == CMD_NOP || cmd == CMD_PRE));
   // R12
   done_with_act_chk: assert property (@(posedge clk) disable iff (rst)
      done |-> (cmd == CMD_ACT && busy));

endmodule

// File: rtl/sdram_rd_pre_dv.sv
module sdram_rd_pre_dv
   import sdram_rd_pre_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic accept,
   input  logic cl3_sel,
   input  logic src_valid,
   output logic rd_valid
);

   logic [MAX_CL-1:0] stg;
   logic              cl_q;

   always_ff @(posedge clk) begin
      if (rst)         cl_q <= 1'b0;
      else if (accept) cl_q <= cl3_sel;
   end

   for (genvar k = 0; k < MAX_CL; k++) begin : g_stage
      if (k == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (rst) stg[0] <= 1'b0;
            else     stg[0] <= src_valid;
         end
      end else begin : g_tail
         always_ff @(posedge clk) begin
            if (rst) stg[k] <= 1'b0;
            else     stg[k] <= stg[k-1];
         end
      end
   end

   assign rd_valid = cl_q ? stg[MAX_CL-1] : stg[MIN_CL-1];

   // R11
   dv_follows_src_chk: assert property (@(posedge clk) disable iff (rst)
      rd_valid |-> (cl_q ? $past(src_valid, 3) : $past(src_valid, 2)));

endmodule

// File: rtl/sdram_rd_pre_sched.sv
module sdram_rd_pre_sched
   import sdram_rd_pre_pkg::*;
#(
   parameter int unsigned BANK_W   = 2,
   parameter int unsigned ROW_W    = 13,
   parameter int unsigned COL_W    = 10,
   parameter int unsigned ADDR_W   = 13,
   parameter int unsigned AP_BIT   = 10,
   parameter int unsigned WANT_W   = 11,
   parameter int unsigned TRP_W    = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cl3_sel,
   input  logic [TRP_W-1:0]  trp_cfg,
   input  logic              req_valid,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   input  logic              req_full_page,
   input  logic [1:0]        req_bl_sel,
   input  logic [WANT_W-1:0] req_want,
   input  logic              req_auto_pre,
   input  logic              req_pre_all,
   output logic [2:0]        cmd_rcw,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [BANK_W-1:0] cmd_ba,
   output logic              dqm,
   output logic              rd_valid,
   output logic              done,
   output logic              busy
);

   logic [WANT_W-1:0] pre_off;
   logic [WANT_W-1:0] dv_len;
   logic              explicit_pre;
   logic              auto_eff;
   logic              accept;
   logic              src_valid;

   sdram_rd_pre_plan #(.WANT_W(WANT_W), .BL_SEL_W(2)) u_plan (
      .want(req_want), .bl_sel(req_bl_sel), .full_page(req_full_page),
      .auto_req(req_auto_pre), .pre_off(pre_off), .dv_len(dv_len),
      .explicit_pre(explicit_pre), .auto_eff(auto_eff)
   );

   sdram_rd_pre_seq #(
      .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W),
      .AP_BIT(AP_BIT), .WANT_W(WANT_W), .TRP_W(TRP_W)
   ) u_seq (
      .clk(clk), .rst(rst), .req_valid(req_valid), .bank(req_bank),
      .row(req_row), .col(req_col), .pre_all(req_pre_all), .trp(trp_cfg),
      .pre_off(pre_off), .dv_len(dv_len), .explicit_pre(explicit_pre),
      .auto_eff(auto_eff), .cmd(cmd_rcw), .addr(cmd_addr), .ba(cmd_ba),
      .done(done), .busy(busy), .accept(accept), .src_valid(src_valid)
   );

   sdram_rd_pre_dv u_dv (
      .clk(clk), .rst(rst), .accept(accept), .cl3_sel(cl3_sel),
      .src_valid(src_valid), .rd_valid(rd_valid)
   );

   assign dqm = 1'b0;

   // R12
   busy_rise_rd_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> (cmd_rcw == CMD_RD));

endmodule

// File: tb/sdram_rd_pre_sched_test.sv
module sdram_rd_pre_sched_test;

   localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_PRE = 3'b010, C_NOP = 3'b111;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cl3_sel = 1'b0;
   logic [3:0]  trp_cfg = 4'd2;
   logic        req_valid = 1'b0;
   logic [1:0]  req_bank = '0;
   logic [12:0] req_row = '0;
   logic [9:0]  req_col = '0;
   logic        req_full_page = 1'b0;
   logic [1:0]  req_bl_sel = '0;
   logic [10:0] req_want = '0;
   logic        req_auto_pre = 1'b0;
   logic        req_pre_all = 1'b0;
   logic [2:0]  cmd_rcw;
   logic [12:0] cmd_addr;
   logic [1:0]  cmd_ba;
   logic        dqm, rd_valid, done, busy;

   always #4 clk = ~clk;

   sdram_rd_pre_sched uut (
      .clk(clk), .rst(rst), .cl3_sel(cl3_sel), .trp_cfg(trp_cfg),
      .req_valid(req_valid), .req_bank(req_bank), .req_row(req_row),
      .req_col(req_col), .req_full_page(req_full_page), .req_bl_sel(req_bl_sel),
      .req_want(req_want), .req_auto_pre(req_auto_pre), .req_pre_all(req_pre_all),
      .cmd_rcw(cmd_rcw), .cmd_addr(cmd_addr), .cmd_ba(cmd_ba), .dqm(dqm),
      .rd_valid(rd_valid), .done(done), .busy(busy)
   );

   typedef struct packed {
      logic [2:0]  cmd;
      logic [12:0] addr;
      logic [1:0]  ba;
      logic        dv;
      logic        dn;
      logic        bs;
   } exp_t;

   exp_t  q_exp[$];
   string q_tag[$];
   int    checks = 0;
   int    failures = 0;
   bit    mon_on = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // monitor: one expected entry per falling edge
   always @(negedge clk) begin
      if (mon_on) begin
         chk(dqm == 1'b0, "R13", "dqm", dqm, 0);
         if (q_exp.size() > 0) begin
            exp_t  e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            chk(cmd_rcw == e.cmd, t, "cmd", cmd_rcw, e.cmd);
            chk(cmd_addr == e.addr && cmd_ba == e.ba, (e.cmd == C_NOP) ? "R10" : t,
                "addr/ba", {cmd_ba, cmd_addr}, {e.ba, e.addr});
            chk(rd_valid == e.dv, "R11", "rd_valid", rd_valid, e.dv);
            chk(done == e.dn && busy == e.bs, "R12", "done/busy",
                {done, busy}, {e.dn, e.bs});
         end
      end
   end

   task automatic run(input string tag, input logic [1:0] bank, input logic [12:0] row,
                      input logic [9:0] col, input bit full, input logic [1:0] bls,
                      input int want, input bit autop, input bit pall, input bit cl3,
                      input int trp, input bit junk);
      int bl, w, p, d, a, cl, n, trpe;
      bit expl, ae;
      bl   = 1 << bls;
      w    = (want == 0) ? 1 : want;
      cl   = cl3 ? 3 : 2;
      trpe = (trp == 0) ? 1 : trp;
      if (full) begin p = w; d = w; expl = 1; ae = 0; end
      else if (autop) begin p = bl; d = (w < bl) ? w : bl; expl = 0; ae = 1; end
      else begin p = (w < bl) ? w : bl; d = p; expl = 1; ae = 0; end
      a = p + trpe;
      n = ((a + 1 > cl + d - 1) ? a + 1 : cl + d - 1) + 1;
      @(negedge clk);
      req_bank = bank; req_row = row; req_col = col; req_full_page = full;
      req_bl_sel = bls; req_want = 11'(want); req_auto_pre = autop;
      req_pre_all = pall; cl3_sel = cl3; trp_cfg = 4'(trp); req_valid = 1'b1;
      @(posedge clk);
      for (int i = 0; i < n; i++) begin
         exp_t e;
         e = '0;
         e.cmd = C_NOP;
         if (i == 0) begin
            e.cmd = C_RD; e.ba = bank; e.addr = {2'b0, ae, col};
         end else if (i == p && expl) begin
            e.cmd = C_PRE; e.ba = bank; e.addr = 13'(pall) << 10;
         end else if (i == a) begin
            e.cmd = C_ACT; e.ba = bank; e.addr = row;
         end
         e.dv = (i >= cl) && (i <= cl + d - 1);
         e.dn = (i == a);
         e.bs = (i <= a);
         q_exp.push_back(e);
         q_tag.push_back(tag);
      end
      @(negedge clk);
      req_valid = 1'b0;
      for (int i = 1; i < n; i++) begin
         @(negedge clk);
         if (junk && i == 2) begin
            req_valid = 1'b1; req_bank = ~bank; req_col = ~col; req_want = 11'd1;
         end
         if (i == 3) req_valid = 1'b0;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk(cmd_rcw == C_NOP, "R1", "cmd", cmd_rcw, C_NOP);
      chk(cmd_addr == 0 && cmd_ba == 0, "R1", "addr/ba", {cmd_ba, cmd_addr}, 0);
      chk(!rd_valid && !done && !busy, "R1", "flags", {rd_valid, done, busy}, 0);
      rst = 1'b0;
      mon_on = 1'b1;
      // R3 full page truncation, CL2
      run("R3", 2'd1, 13'h0abc, 10'h045, 1, 2'd0, 4, 0, 0, 0, 3, 0);
      // R7 full page ignores auto flag, CL3, with junk request (R14)
      run("R7", 2'd2, 13'h1234, 10'h3f0, 1, 2'd2, 6, 1, 0, 1, 2, 1);
      // R3 fixed BL4 truncated to 2, CL3; R8 all-bank precharge
      run("R8", 2'd3, 13'h0055, 10'h011, 0, 2'd2, 2, 0, 1, 1, 2, 0);
      // R4 fixed BL4 run to completion, CL2
      run("R4", 2'd0, 13'h1fff, 10'h200, 0, 2'd2, 9, 0, 0, 0, 2, 0);
      // R5 wanted count zero
      run("R5", 2'd1, 13'h0001, 10'h0aa, 0, 2'd3, 0, 0, 0, 0, 2, 0);
      // R6 auto precharge BL8, three wanted
      run("R6", 2'd2, 13'h0777, 10'h155, 0, 2'd3, 3, 1, 0, 0, 2, 0);
      // R9 tRP of zero counts as one, CL3
      run("R9", 2'd3, 13'h0f0f, 10'h0c3, 0, 2'd1, 2, 0, 0, 1, 0, 0);
      // R14 junk request while busy, fixed BL8 truncated
      run("R14", 2'd0, 13'h0321, 10'h123, 0, 2'd3, 5, 0, 1, 0, 4, 1);
      // R2 back-to-back full page of one word, CL3
      run("R2", 2'd1, 13'h0444, 10'h001, 1, 2'd0, 1, 0, 0, 1, 1, 0);
      repeat (4) @(negedge clk);
      // R10 idle after the last sequence
      chk(q_exp.size() == 0, "R10", "queue drained", q_exp.size(), 0);
      chk(cmd_rcw == C_NOP && !busy, "R10", "idle", {cmd_rcw, busy}, {C_NOP, 1'b0});
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule